// File: doc/BRIEF.md
# Interrupt Acceptance and Status Controller

This block decides, cycle by cycle, whether a processor core takes an interrupt, and it keeps the status, saved-status and exception-return address registers that go with that decision. In internal mode a bank of request lines is masked by a software-written enable register, and any surviving pending bit is taken toward a fixed handler address. In external mode a single request arrives with its own handler address, target register-set number, priority level and a non-maskable flag. The block filters that request against the status word before it accepts it.

On acceptance the current status word is copied into saved status. The interrupt-enable bit is cleared, the register set in use is recorded as the previous set, and the current set switches to the target. The exception-return address captures the address of the next instruction. A return command copies the saved status word back into status as a whole and presents the exception-return address as the resume point. Acceptance and the handler address appear combinationally in the request cycle, and the register updates land on the following clock edge.

Top module: `irq_accept_ctrl`

## Requirements
- R1: The pending output is, bit by bit, the request lines ANDed with the enable register. The enable register is written by `ien_we`/`ien_wdata`, resets to 0, and keeps its value when no write is made.
- R2: In internal mode (`mode_ext`=0), the block takes an interrupt when the status enable bit is set and at least one pending bit is set. The handler address is the parameter `INT_VECTOR`, and the target set is the current set.
- R3: While the status enable bit (status bit 0) is clear, no maskable request is taken in either mode.
- R4: In external mode, a maskable request is taken only when `ext_level` is strictly greater than the status level field (status bits 7:2).
- R5: In external mode, a request whose `ext_set` equals the current set (status bits 13:8) is taken only when the register-set enable bit (status bit 1) is set. This also applies to non-maskable requests.
- R6: A non-maskable external request (`ext_nmi`=1) is taken regardless of the status enable bit and the level field.
- R7: On acceptance (`take_o`=1), at the next edge saved status gets the old status word. In status, bit 0 is cleared, the previous-set field (bits 19:14) gets the old current set, and the current set gets the target. The exception-return address gets `next_pc`. `handler_o` shows the handler address in the acceptance cycle.
- R8: With `eret`=1, status is loaded with the whole saved-status word at the next edge. `ret_valid_o` is 1 and `ret_pc_o` shows the exception-return address. No interrupt is taken in that cycle.
- R9: Status, saved status, the exception-return address and the enable register reset to 0. Status and saved status are writable through `sts_we` and `est_we`. An acceptance in the same cycle overrides both writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | 1 selects external-request mode, 0 internal mode |
| irq_req | input | NUM_IRQ | Internal request lines |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | NUM_IRQ | Enable register write value |
| ext_valid | input | 1 | External request present |
| ext_handler | input | ADDR_W | External request handler address |
| ext_set | input | SET_W | External request target register set |
| ext_level | input | LVL_W | External request priority level |
| ext_nmi | input | 1 | External request is non-maskable |
| next_pc | input | ADDR_W | Address of the instruction after the interrupted one |
| eret | input | 1 | Return-from-exception command |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | STATUS_W | Status write value |
| est_we | input | 1 | Saved-status write strobe |
| est_wdata | input | STATUS_W | Saved-status write value |
| take_o | output | 1 | Interrupt accepted this cycle |
| handler_o | output | ADDR_W | Handler address of the accepted interrupt |
| ret_valid_o | output | 1 | Return in progress |
| ret_pc_o | output | ADDR_W | Exception-return address |
| status_o | output | STATUS_W | Status register |
| estatus_o | output | STATUS_W | Saved-status register |
| ipend_o | output | NUM_IRQ | Pending bits |
| ienable_o | output | NUM_IRQ | Enable register |

## Verification
External-mode acceptance is driven from a table of status words and requests. The table places the request level below, equal to and above the level field, including the top of the level range. This separates a strict comparison from a non-strict one. It also toggles the enable bit against the non-maskable flag, and it sets the target set equal to and different from the current set with the register-set enable on and off. Each combination shows whether one gate is checked independently of the others. Directed sequences then cover internal-mode masking, the register contents after an accepted interrupt, a return that collides with a request, and a software write that collides with an acceptance.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int SET_W = 6;
  localparam int LVL_W = 6;

  typedef struct packed {
    logic [SET_W-1:0] prs;
    logic [SET_W-1:0] crs;
    logic [LVL_W-1:0] il;
    logic             rsie;
    logic             pie;
  } status_t;

  localparam int STATUS_W = $bits(status_t);

  // strict priority comparison for external requests
  function automatic logic level_wins(logic [LVL_W-1:0] req, logic [LVL_W-1:0] cur);
    return req > cur;
  endfunction

  // status word produced when an interrupt is entered
  function automatic status_t enter_status(status_t s, logic [SET_W-1:0] tgt);
    status_t r;
    r     = s;
    r.pie = 1'b0;
    r.prs = s.crs;
    r.crs = tgt;
    return r;
  endfunction
endpackage

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ien_we,
  input  logic [NUM_IRQ-1:0] ien_wdata,
  input  logic [NUM_IRQ-1:0] irq_req,
  output logic [NUM_IRQ-1:0] ienable_o,
  output logic [NUM_IRQ-1:0] ipend_o,
  output logic               any_pend_o
);
  logic [NUM_IRQ-1:0] ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_wdata;
  end

  assign ienable_o  = ien_q;
  assign ipend_o    = irq_req & ien_q;
  assign any_pend_o = |ipend_o;

  // R1
  ien_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_we |=> ienable_o == $past(ien_wdata));
  // R1
  ien_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_we |=> $stable(ienable_o));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] INT_VECTOR = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ext,
  input  logic              any_pend,
  input  status_t           cur,
  input  logic              ext_valid,
  input  logic [ADDR_W-1:0] ext_handler,
  input  logic [SET_W-1:0]  ext_set,
  input  logic [LVL_W-1:0]  ext_level,
  input  logic              ext_nmi,
  input  logic              eret,
  output logic              accept_o,
  output logic [SET_W-1:0]  target_set_o,
  output logic [ADDR_W-1:0] handler_o
);
  logic int_ok;
  logic ext_lvl_ok;
  logic ext_set_ok;
  logic ext_ok;

  assign int_ok     = !mode_ext && cur.pie && any_pend;
  assign ext_lvl_ok = ext_nmi || (cur.pie && level_wins(ext_level, cur.il));
  assign ext_set_ok = (ext_set != cur.crs) || cur.rsie;
  assign ext_ok     = mode_ext && ext_valid && ext_lvl_ok && ext_set_ok;

  assign accept_o     = !eret && (int_ok || ext_ok);
  assign target_set_o = mode_ext ? ext_set : cur.crs;
  assign handler_o    = mode_ext ? ext_handler : INT_VECTOR[ADDR_W-1:0];

  // R3
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && !(mode_ext && ext_nmi) |-> cur.pie);
  // R4
  level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && mode_ext && !ext_nmi |-> ext_level > cur.il);
  // R5
  rset_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && mode_ext && (ext_set == cur.crs) |-> cur.rsie);
  // R8
  eret_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eret |-> !accept_o);
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [SET_W-1:0]  target_set,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              eret,
  input  logic              sts_we,
  input  status_t           sts_wdata,
  input  logic              est_we,
  input  status_t           est_wdata,
  output status_t           status_o,
  output status_t           estatus_o,
  output logic [ADDR_W-1:0] ea_o
);
  status_t           sts_q, est_q, sts_d, est_d;
  logic [ADDR_W-1:0] ea_q;

  always_comb begin
    sts_d = sts_q;
    if (eret)        sts_d = est_q;
    else if (accept) sts_d = enter_status(sts_q, target_set);
    else if (sts_we) sts_d = sts_wdata;
  end

  always_comb begin
    est_d = est_q;
    if (accept)      est_d = sts_q;
    else if (est_we) est_d = est_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      est_q <= '0;
      ea_q  <= '0;
    end else begin
      sts_q <= sts_d;
      est_q <= est_d;
      if (accept) ea_q <= next_pc;
    end
  end

  assign status_o  = sts_q;
  assign estatus_o = est_q;
  assign ea_o      = ea_q;

  // R7
  save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (estatus_o == $past(status_o)) && !status_o.pie
               && (status_o.crs == $past(target_set))
               && (status_o.prs == $past(status_o.crs)));
  // R7
  ea_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ea_o == $past(next_pc));
  // R8
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eret |=> status_o == $past(estatus_o));
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          NUM_IRQ    = 32,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] INT_VECTOR = 32'h0000_0100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_ext,
  input  logic [NUM_IRQ-1:0]  irq_req,
  input  logic                ien_we,
  input  logic [NUM_IRQ-1:0]  ien_wdata,
  input  logic                ext_valid,
  input  logic [ADDR_W-1:0]   ext_handler,
  input  logic [SET_W-1:0]    ext_set,
  input  logic [LVL_W-1:0]    ext_level,
  input  logic                ext_nmi,
  input  logic [ADDR_W-1:0]   next_pc,
  input  logic                eret,
  input  logic                sts_we,
  input  logic [STATUS_W-1:0] sts_wdata,
  input  logic                est_we,
  input  logic [STATUS_W-1:0] est_wdata,
  output logic                take_o,
  output logic [ADDR_W-1:0]   handler_o,
  output logic                ret_valid_o,
  output logic [ADDR_W-1:0]   ret_pc_o,
  output logic [STATUS_W-1:0] status_o,
  output logic [STATUS_W-1:0] estatus_o,
  output logic [NUM_IRQ-1:0]  ipend_o,
  output logic [NUM_IRQ-1:0]  ienable_o
);
  logic              any_pend;
  logic              accept;
  logic [SET_W-1:0]  target_set;
  status_t           cur_sts, cur_est;
  logic [ADDR_W-1:0] ea;

  irq_pend_unit #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .irq_req(irq_req),
    .ienable_o(ienable_o), .ipend_o(ipend_o), .any_pend_o(any_pend)
  );

  irq_arbiter #(.ADDR_W(ADDR_W), .INT_VECTOR(INT_VECTOR)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .mode_ext(mode_ext), .any_pend(any_pend), .cur(cur_sts),
    .ext_valid(ext_valid), .ext_handler(ext_handler),
    .ext_set(ext_set), .ext_level(ext_level), .ext_nmi(ext_nmi),
    .eret(eret),
    .accept_o(accept), .target_set_o(target_set), .handler_o(handler_o)
  );

  irq_status_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .target_set(target_set), .next_pc(next_pc),
    .eret(eret),
    .sts_we(sts_we), .sts_wdata(status_t'(sts_wdata)),
    .est_we(est_we), .est_wdata(status_t'(est_wdata)),
    .status_o(cur_sts), .estatus_o(cur_est), .ea_o(ea)
  );

  assign take_o      = accept;
  assign ret_valid_o = eret;
  assign ret_pc_o    = ea;
  assign status_o    = cur_sts;
  assign estatus_o   = cur_est;
endmodule

// File: tb/irq_accept_ctrl_tb.sv
module irq_accept_ctrl_tb;
  localparam logic [31:0] VEC_ADDR = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_ext;
  logic [31:0] irq_req;
  logic        ien_we;
  logic [31:0] ien_wdata;
  logic        ext_valid;
  logic [31:0] ext_handler;
  logic [5:0]  ext_set;
  logic [5:0]  ext_level;
  logic        ext_nmi;
  logic [31:0] next_pc;
  logic        eret;
  logic        sts_we;
  logic [19:0] sts_wdata;
  logic        est_we;
  logic [19:0] est_wdata;
  logic        take_o;
  logic [31:0] handler_o;
  logic        ret_valid_o;
  logic [31:0] ret_pc_o;
  logic [19:0] status_o;
  logic [19:0] estatus_o;
  logic [31:0] ipend_o;
  logic [31:0] ienable_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_accept_ctrl #(.INT_VECTOR(VEC_ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .irq_req(irq_req),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .ext_valid(ext_valid),
    .ext_handler(ext_handler), .ext_set(ext_set), .ext_level(ext_level),
    .ext_nmi(ext_nmi), .next_pc(next_pc), .eret(eret),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .est_we(est_we), .est_wdata(est_wdata),
    .take_o(take_o), .handler_o(handler_o), .ret_valid_o(ret_valid_o),
    .ret_pc_o(ret_pc_o), .status_o(status_o), .estatus_o(estatus_o),
    .ipend_o(ipend_o), .ienable_o(ienable_o)
  );

  // status word: {prs[19:14], crs[13:8], il[7:2], rsie[1], pie[0]}
  function automatic logic [19:0] mk(logic pie, logic rsie, logic [5:0] il,
                                      logic [5:0] crs, logic [5:0] prs);
    return {prs, crs, il, rsie, pie};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {status[33:14], level[13:8], set[7:2], nmi[1], expected take[0]}
  localparam logic [33:0] VEC [10] = '{
    {6'd0, 6'd0, 6'd3,  1'b0, 1'b1, 6'd4,  6'd2, 1'b0, 1'b1},
    {6'd0, 6'd0, 6'd4,  1'b0, 1'b1, 6'd4,  6'd2, 1'b0, 1'b0},
    {6'd0, 6'd0, 6'd5,  1'b0, 1'b1, 6'd4,  6'd2, 1'b0, 1'b0},
    {6'd0, 6'd0, 6'd0,  1'b0, 1'b0, 6'd9,  6'd2, 1'b0, 1'b0},
    {6'd0, 6'd0, 6'd7,  1'b0, 1'b0, 6'd0,  6'd2, 1'b1, 1'b1},
    {6'd0, 6'd2, 6'd1,  1'b0, 1'b1, 6'd5,  6'd2, 1'b0, 1'b0},
    {6'd0, 6'd2, 6'd1,  1'b1, 1'b1, 6'd5,  6'd2, 1'b0, 1'b1},
    {6'd0, 6'd3, 6'd0,  1'b0, 1'b0, 6'd0,  6'd3, 1'b1, 1'b0},
    {6'd0, 6'd0, 6'd62, 1'b0, 1'b1, 6'd63, 6'd1, 1'b0, 1'b1},
    {6'd0, 6'd0, 6'd63, 1'b0, 1'b1, 6'd63, 6'd1, 1'b0, 1'b0}
  };
  localparam string VEC_REQ [10] = '{"R4", "R4", "R4", "R3", "R6",
                                     "R5", "R5", "R5", "R4", "R4"};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [19:0] s_a, s_b;
    rst_n = 0; mode_ext = 1; irq_req = 0; ien_we = 0; ien_wdata = 0;
    ext_valid = 0; ext_handler = 0; ext_set = 0; ext_level = 0; ext_nmi = 0;
    next_pc = 0; eret = 0; sts_we = 0; sts_wdata = 0; est_we = 0; est_wdata = 0;
    repeat (3) tick();
    rst_n = 1;
    #1;
    // R9 reset state
    check("R9 status", 64'(status_o), 64'h0);
    check("R9 estatus", 64'(estatus_o), 64'h0);
    check("R9 ea", 64'(ret_pc_o), 64'h0);
    check("R1 ienable", 64'(ienable_o), 64'h0);
    check("R9 take", 64'(take_o), 64'h0);

    // external-mode acceptance table (R3 R4 R5 R6)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ext_valid = 0; sts_we = 1; sts_wdata = VEC[i][33:14];
      tick();
      sts_we = 0; ext_valid = 1; ext_level = VEC[i][13:8];
      ext_set = VEC[i][7:2]; ext_nmi = VEC[i][1];
      #1;
      check(VEC_REQ[i], 64'(take_o), 64'(VEC[i][0]));
    end
    @(negedge clk);
    ext_valid = 0; ext_nmi = 0;

    // R1 pending masking
    ien_we = 1; ien_wdata = 32'h0000_00F0;
    tick();
    ien_we = 0; ien_wdata = 32'hFFFF_FFFF; irq_req = 32'h0000_0FF0;
    #1;
    check("R1 ipend", 64'(ipend_o), 64'h0000_00F0);
    tick();
    check("R1 ienable hold", 64'(ienable_o), 64'h0000_00F0);

    // R2 internal mode acceptance
    irq_req = 0; mode_ext = 0;
    s_a = mk(1'b1, 1'b0, 6'd0, 6'd5, 6'd0);
    sts_we = 1; sts_wdata = s_a;
    tick();
    sts_we = 0; irq_req = 32'h0000_0010; next_pc = 32'h0000_0200;
    #1;
    check("R2 take", 64'(take_o), 64'h1);
    check("R2 handler", 64'(handler_o), 64'(VEC_ADDR));
    tick();
    check("R7 estatus", 64'(estatus_o), 64'(s_a));
    check("R7 status", 64'(status_o), 64'(mk(1'b0, 1'b0, 6'd0, 6'd5, 6'd5)));
    check("R7 ea", 64'(ret_pc_o), 64'h0000_0200);
    #1;
    check("R3 internal masked", 64'(take_o), 64'h0);

    // R8 return collides with a non-maskable request
    @(negedge clk);
    irq_req = 0; mode_ext = 1; eret = 1;
    ext_valid = 1; ext_nmi = 1; ext_set = 6'd9;
    #1;
    check("R8 no take", 64'(take_o), 64'h0);
    check("R8 ret_valid", 64'(ret_valid_o), 64'h1);
    check("R8 ret_pc", 64'(ret_pc_o), 64'h0000_0200);
    tick();
    eret = 0; ext_valid = 0; ext_nmi = 0;
    check("R8 restore", 64'(status_o), 64'(s_a));

    // R7 external acceptance
    s_b = mk(1'b1, 1'b1, 6'd2, 6'd1, 6'd0);
    sts_we = 1; sts_wdata = s_b;
    tick();
    sts_we = 0; ext_valid = 1; ext_level = 6'd3; ext_set = 6'd4;
    ext_handler = 32'hABCD_0100; next_pc = 32'h0000_1000;
    #1;
    check("R7 take", 64'(take_o), 64'h1);
    check("R7 handler", 64'(handler_o), 64'hABCD_0100);
    tick();
    ext_valid = 0;
    check("R7 status ext", 64'(status_o), 64'(mk(1'b0, 1'b1, 6'd2, 6'd4, 6'd1)));
    check("R7 estatus ext", 64'(estatus_o), 64'(s_b));
    check("R7 ea ext", 64'(ret_pc_o), 64'h0000_1000);

    // R9 acceptance overrides software writes
    ext_valid = 1; ext_nmi = 1; ext_set = 6'd7; next_pc = 32'h0000_2000;
    sts_we = 1; sts_wdata = 20'hFFFFF; est_we = 1; est_wdata = 20'h0ABCD;
    tick();
    ext_valid = 0; ext_nmi = 0; sts_we = 0; est_we = 0;
    check("R9 status accept wins", 64'(status_o), 64'(mk(1'b0, 1'b1, 6'd2, 6'd7, 6'd4)));
    check("R9 estatus accept wins", 64'(estatus_o), 64'(mk(1'b0, 1'b1, 6'd2, 6'd4, 6'd1)));
    est_we = 1; est_wdata = 20'h12345;
    tick();
    est_we = 0;
    check("R9 estatus write", 64'(estatus_o), 64'h12345);
    sts_we = 1; sts_wdata = 20'h54321;
    tick();
    sts_we = 0;
    check("R9 status write", 64'(status_o), 64'h54321);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule